// File: doc/BRIEF.md
# Partitionable FIR Multiply-Accumulate Engine

This block is a filter accelerator on a register-mapped bus. It holds 64 coefficient entries and 64 sample-history entries, and it has one signed 24x24 multiply-accumulate datapath that handles one filter tap per clock. At run time the shared storage works as one 64-tap direct-form FIR, or it is split into four independent 16-tap FIR channels of 16 entries each. Software or a DMA controller writes samples into a one-deep hold register for each channel. The engine picks a channel that is ready, walks its taps from the newest sample to the oldest, and places a rounded, saturated 24-bit result in that channel's output register. Request lines tell a DMA controller when a channel can accept a sample and when a result is waiting.

The control is a four-state machine:
- `S_IDLE` waits for an eligible channel. The transition *grant* moves to `S_LOAD`.
- `S_LOAD` writes the held sample into the history and clears the accumulator. The transition *start* moves to `S_MAC`.
- `S_MAC` performs one multiply-accumulate per cycle. The transition *last tap* moves to `S_DONE`.
- `S_DONE` stores the output and advances the channel's write pointer. The transition *retire* returns to `S_IDLE`.

Bus map:
| Address | Access | Content |
|---|---|---|
| 0x00–0x3F | read/write | Coefficient window |
| 0x40+c | write | Sample input for channel c |
| 0x44+c | read | Output of channel c |
| 0x48 | read/write | Configuration and status |

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, all coefficients and sample history are zero and single-filter mode is selected. The engine is idle, `dma_out_req` is 0, and `dma_in_req` is 4'b0001.
- R2: A write to address k in 0x00–0x3F sets coefficient k, and a read of k returns it. Such a write is ignored while the engine is busy.
- R3: Address 0x48 reads back {busy at bit 1, mode at bit 0}. Mode 1 means four 16-tap channels and mode 0 means one 64-tap filter. A write there sets the mode from bit 0, and the write is ignored while the engine is busy.
- R4: A write to 0x40+c loads the hold register of channel c. In single mode the channel is forced to 0. A write to a full hold register is ignored. `dma_in_req[c]` is 1 exactly when the hold register of channel c is empty and the channel exists in the current mode.
- R5: Each output equals the sum over k of coef[base+k] times sample[n-k]. Sample n is the newest sample of that channel, and earlier samples come from its circular history. A new sample replaces the oldest one.
- R6: In single mode one filter uses all 64 pairs, with base 0.
- R7: In four-channel mode channel c uses entries 16c to 16c+15 for both coefficients and history. The channels are independent.
- R8: The engine handles one tap per clock. From grant to retire the busy status lasts taps+2 cycles: 66 in single mode and 18 in four-channel mode.
- R9: The 54-bit accumulator cannot overflow. The output is (acc + 2^22) shifted right arithmetically by 23, then saturated to the range -8388608 to 8388607.
- R10: A finished result sets `dma_out_req[c]`. The request stays set until address 0x44+c is read with `rd_en`. A channel whose output is unread is not processed.
- R11: Channels that are eligible are served in round-robin order, starting after the channel served last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 24 | Bus write data |
| rd_en | input | 1 | Read strobe; it consumes an output register |
| rd_addr | input | 8 | Bus read address |
| rd_data | output | 24 | Combinational read data |
| dma_in_req | output | 4 | Per-channel request: can accept a sample |
| dma_out_req | output | 4 | Per-channel request: a result is waiting |

## Verification
The bench builds the engine with its defaults: 64 pairs, four channels, 24-bit data and a 54-bit accumulator. These values bring both the 64-tap and the 16-tap partitions within reach, along with full-scale saturation in both directions and the rounding edges just above and below half an LSB. A behavioural model keeps a sample queue per channel, with the newest sample first, and computes every expected output from it. The bench drives four-channel traffic out of order, so the round-robin ordering becomes visible on the output requests.

// File: rtl/fir_eng_pkg.sv
package fir_eng_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_MAC,
        S_DONE
    } eng_state_e;
endpackage

// File: rtl/fir_rr_arbiter.sv
module fir_rr_arbiter #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               adv_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] cand;

    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        cand  = '0;
        for (int i = 1; i <= NUM_REQ; i++) begin
            cand = last_q + IDX_W'(i);
            if (!any_o && req_i[cand]) begin
                any_o = 1'b1;
                idx_o = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IDX_W'(NUM_REQ - 1);
        else if (adv_i && any_o) last_q <= idx_o;
    end

    // R11: a granted index always points at a live request
    assert_grant_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);
endmodule

// File: rtl/fir_tap_store.sv
module fir_tap_store #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_waddr,
    input  logic [DATA_W-1:0] coef_wdata,
    input  logic              hist_we,
    input  logic [IDX_W-1:0]  hist_waddr,
    input  logic [DATA_W-1:0] hist_wdata,
    input  logic [IDX_W-1:0]  coef_raddr,
    input  logic [IDX_W-1:0]  hist_raddr,
    input  logic [IDX_W-1:0]  bus_raddr,
    output logic [DATA_W-1:0] coef_rdata,
    output logic [DATA_W-1:0] hist_rdata,
    output logic [DATA_W-1:0] bus_coef_rdata
);
    logic [DATA_W-1:0] coef_mem [DEPTH];
    logic [DATA_W-1:0] hist_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                coef_mem[i] <= '0;
                hist_mem[i] <= '0;
            end
        end else begin
            if (coef_we) coef_mem[coef_waddr] <= coef_wdata;
            if (hist_we) hist_mem[hist_waddr] <= hist_wdata;
        end
    end

    assign coef_rdata     = coef_mem[coef_raddr];
    assign hist_rdata     = hist_mem[hist_raddr];
    assign bus_coef_rdata = coef_mem[bus_raddr];
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
    parameter int DATA_W     = 24,
    parameter int ACC_W      = 54,
    parameter int FRAC_SHIFT = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] coef_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_MIN = -SAT_MAX - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(64'sd1 <<< (FRAC_SHIFT - 1));

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  rounded;
    logic signed [ACC_W-1:0]  shifted;

    assign prod     = $signed(sample_i) * $signed(coef_i);
    assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    assign rounded  = acc_q + HALF;
    assign shifted  = rounded >>> FRAC_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (clr_i) acc_q <= '0;
        else if (en_i)  acc_q <= acc_q + prod_ext;
    end

    always_comb begin
        if (shifted > SAT_MAX)      result_o = SAT_MAX[DATA_W-1:0];
        else if (shifted < SAT_MIN) result_o = SAT_MIN[DATA_W-1:0];
        else                        result_o = shifted[DATA_W-1:0];
    end

    // R9: adding a same-signed product never flips the accumulator sign
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && (acc_q[ACC_W-1] == prod_ext[ACC_W-1]))
        |=> (acc_q[ACC_W-1] == $past(acc_q[ACC_W-1])));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_eng_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int TOTAL_TAPS = 64,
    parameter int NUM_CH     = 4,
    parameter int ACC_W      = 54,
    parameter int FRAC_SHIFT = 23,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] dma_in_req,
    output logic [NUM_CH-1:0] dma_out_req
);
    localparam int IDX_W   = $clog2(TOTAL_TAPS);
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CH_TAPS = TOTAL_TAPS / NUM_CH;
    localparam int SUB_W   = $clog2(CH_TAPS);
    localparam logic [ADDR_W-1:0] SAMP_BASE = ADDR_W'(TOTAL_TAPS);
    localparam logic [ADDR_W-1:0] OUT_BASE  = ADDR_W'(TOTAL_TAPS + NUM_CH);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(TOTAL_TAPS + 2 * NUM_CH);

    eng_state_e state_q, state_d;
    logic              quad_q;
    logic [CH_W-1:0]   cur_ch;
    logic [IDX_W-1:0]  tap_q;
    logic [IDX_W-1:0]  wp_q   [NUM_CH];
    logic [DATA_W-1:0] hold_d [NUM_CH];
    logic [DATA_W-1:0] out_d  [NUM_CH];
    logic [NUM_CH-1:0] hold_v, out_v, ch_live, eligible;

    logic              busy, any_ready;
    logic [CH_W-1:0]   pick_ch, samp_ch, rd_ch;
    logic [IDX_W-1:0]  ch_base, len_m1;
    logic              wr_coef, wr_samp, wr_cfg, rd_out;
    logic [DATA_W-1:0] coef_rd, hist_rd, bus_coef, mac_result;

    assign busy    = (state_q != S_IDLE);
    assign len_m1  = quad_q ? IDX_W'(CH_TAPS - 1) : IDX_W'(TOTAL_TAPS - 1);
    assign ch_base = quad_q ? (IDX_W'(cur_ch) << SUB_W) : '0;

    assign wr_coef = wr_en && (wr_addr < SAMP_BASE);
    assign wr_samp = wr_en && (wr_addr >= SAMP_BASE) && (wr_addr < OUT_BASE);
    assign wr_cfg  = wr_en && (wr_addr == CFG_ADDR);
    assign samp_ch = quad_q ? CH_W'(wr_addr - SAMP_BASE) : '0;
    assign rd_out  = (rd_addr >= OUT_BASE) && (rd_addr < CFG_ADDR);
    assign rd_ch   = CH_W'(rd_addr - OUT_BASE);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            assign ch_live[c]     = quad_q || (c == 0);
            assign eligible[c]    = hold_v[c] && !out_v[c] && ch_live[c];
            assign dma_in_req[c]  = !hold_v[c] && ch_live[c];
            assign dma_out_req[c] = out_v[c];

            // R10: a waiting result stays flagged until its register is read
            assert_out_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (dma_out_req[c] && !(rd_en && rd_addr == ADDR_W'(TOTAL_TAPS + NUM_CH + c)))
                |=> dma_out_req[c]);
        end
    endgenerate

    fir_rr_arbiter #(.NUM_REQ(NUM_CH), .IDX_W(CH_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (eligible),
        .adv_i (state_q == S_IDLE),
        .idx_o (pick_ch),
        .any_o (any_ready)
    );

    fir_tap_store #(.DATA_W(DATA_W), .DEPTH(TOTAL_TAPS), .IDX_W(IDX_W)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .coef_we        (wr_coef && !busy),
        .coef_waddr     (wr_addr[IDX_W-1:0]),
        .coef_wdata     (wr_data),
        .hist_we        (state_q == S_LOAD),
        .hist_waddr     (ch_base | (wp_q[cur_ch] & len_m1)),
        .hist_wdata     (hold_d[cur_ch]),
        .coef_raddr     (ch_base | (tap_q & len_m1)),
        .hist_raddr     (ch_base | ((wp_q[cur_ch] - tap_q) & len_m1)),
        .bus_raddr      (rd_addr[IDX_W-1:0]),
        .coef_rdata     (coef_rd),
        .hist_rdata     (hist_rd),
        .bus_coef_rdata (bus_coef)
    );

    fir_mac_unit #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_SHIFT(FRAC_SHIFT)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_q == S_LOAD),
        .en_i     (state_q == S_MAC),
        .sample_i (hist_rd),
        .coef_i   (coef_rd),
        .result_o (mac_result)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions: grant, start, last tap, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_ready) state_d = S_LOAD;
            S_LOAD: state_d = S_MAC;
            S_MAC:  if (tap_q == len_m1) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quad_q <= 1'b0;
            cur_ch <= '0;
            tap_q  <= '0;
            hold_v <= '0;
            out_v  <= '0;
            for (int i = 0; i < NUM_CH; i++) begin
                wp_q[i]   <= '0;
                hold_d[i] <= '0;
                out_d[i]  <= '0;
            end
        end else begin
            if (rd_en && rd_out) out_v[rd_ch] <= 1'b0;
            if (wr_samp && !hold_v[samp_ch]) begin
                hold_v[samp_ch] <= 1'b1;
                hold_d[samp_ch] <= wr_data;
            end
            if (wr_cfg && !busy) quad_q <= wr_data[0];
            unique case (state_q)
                S_IDLE: if (any_ready) cur_ch <= pick_ch;
                S_LOAD: begin
                    hold_v[cur_ch] <= 1'b0;
                    tap_q          <= '0;
                end
                S_MAC:  tap_q <= tap_q + IDX_W'(1);
                S_DONE: begin
                    out_d[cur_ch] <= mac_result;
                    out_v[cur_ch] <= 1'b1;
                    wp_q[cur_ch]  <= (wp_q[cur_ch] + IDX_W'(1)) & len_m1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (rd_addr < SAMP_BASE)     rd_data = bus_coef;
        else if (rd_out)             rd_data = out_d[rd_ch];
        else if (rd_addr == CFG_ADDR) rd_data = DATA_W'({busy, quad_q});
        else                         rd_data = '0;
    end

    // R10: retiring a result raises that channel's output request
    assert_retire_sets_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> dma_out_req[$past(cur_ch)]);

    // R8: the load step is always followed by accumulation
    assert_load_then_mac_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD) |=> (state_q == S_MAC));
endmodule

// File: tb/fir_mac_engine_tb.sv
module fir_mac_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS = 64;
    localparam int NCH  = 4;
    localparam logic [7:0] SAMP = 8'h40;
    localparam logic [7:0] OUTB = 8'h44;
    localparam logic [7:0] CFG  = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = CFG;
    logic [23:0] rd_data;
    logic [3:0]  dma_in_req, dma_out_req;

    fir_mac_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    longint ref_coef [TAPS];
    longint ref_q [NCH][$];
    bit ref_quad;

    task automatic check(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_init(bit quad);
        ref_quad = quad;
        for (int c = 0; c < NCH; c++) begin
            ref_q[c].delete();
            for (int k = 0; k < (quad ? 16 : 64); k++) ref_q[c].push_back(0);
        end
    endfunction

    function automatic longint model_push(int ch, longint x);
        longint acc = 0;
        longint r;
        int len  = ref_quad ? 16 : 64;
        int base = ref_quad ? ch * 16 : 0;
        ref_q[ch].push_front(x);
        void'(ref_q[ch].pop_back());
        for (int k = 0; k < len; k++) acc += ref_coef[base + k] * ref_q[ch][k];
        r = (acc + (64'sd1 <<< 22)) >>> 23;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic bus_wr(logic [7:0] a, longint d);
        wr_en = 1'b1; wr_addr = a; wr_data = d[23:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, bit consume, output longint v);
        rd_addr = a; rd_en = consume;
        #1;
        v = longint'($signed(rd_data));
        @(negedge clk);
        rd_en = 1'b0; rd_addr = CFG;
    endtask

    task automatic wait_done(output int cyc);
        bit seen = 0;
        cyc = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rd_data[1]) begin cyc++; seen = 1; end
            else if (seen) break;
        end
    endtask

    task automatic do_reset(bit quad);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < TAPS; k++) ref_coef[k] = 0;
        model_init(quad);
    endtask

    task automatic run_sample(int ch, logic [7:0] addr, longint x, int busy_exp);
        longint exp_v, v;
        int cyc;
        exp_v = model_push(ch, x);
        bus_wr(addr, x);
        check("R4 hold full clears in-request", dma_in_req[ch], 0);
        wait_done(cyc);
        check("R8 busy cycles", cyc, busy_exp);
        check("R10 out-request set", dma_out_req[ch], 1);
        bus_rd(OUTB + 8'(ch), 1'b1, v);
        check("R5 filter output", v, exp_v);
        check("R10 out-request cleared by read", dma_out_req[ch], 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        longint v, e1, e2;
        int cyc;
        int order [$];
        bit seen [NCH];

        // ---------- single 64-tap mode ----------
        do_reset(1'b0);
        bus_rd(CFG, 1'b0, v);       check("R1 status after reset", v, 0);
        check("R1 out-request after reset", dma_out_req, 0);
        check("R1 in-request after reset", dma_in_req, 4'b0001);
        bus_rd(OUTB, 1'b0, v);      check("R1 output after reset", v, 0);
        bus_rd(8'd5, 1'b0, v);      check("R1 coefficient after reset", v, 0);

        for (int k = 0; k < TAPS; k++) begin
            ref_coef[k] = (((k * 37) % 101) - 50) * 4099;
            bus_wr(8'(k), ref_coef[k]);
        end
        bus_rd(8'd7, 1'b0, v);      check("R2 coefficient readback", v, ref_coef[7]);

        // R6: full 64-tap walk over the shared store
        run_sample(0, SAMP, 1000003, 66);
        run_sample(0, SAMP, -2500000, 66);
        run_sample(0, SAMP, 4194304, 66);
        run_sample(0, SAMP + 8'd2, 8388607, 66);   // R4: channel forced to 0
        check("R6 R4 no request on unused channel", dma_in_req, 4'b0001);

        // R10: unread result blocks the channel; R4: full hold ignores writes
        e1 = model_push(0, 777777);
        bus_wr(SAMP, 777777);
        wait_done(cyc);
        e2 = model_push(0, -123456);
        bus_wr(SAMP, -123456);
        cyc = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (rd_data[1]) cyc++;
        end
        check("R10 blocked channel stays idle", cyc, 0);
        bus_wr(SAMP, 5555555);
        check("R4 full hold keeps in-request low", dma_in_req[0], 0);
        bus_rd(OUTB, 1'b1, v);      check("R10 held result", v, e1);
        wait_done(cyc);
        check("R8 busy cycles after unblock", cyc, 66);
        bus_rd(OUTB, 1'b1, v);      check("R4 ignored sample left no trace", v, e2);

        // R2/R3: writes during busy are ignored
        e1 = model_push(0, 31337);
        bus_wr(SAMP, 31337);
        @(negedge clk);
        bus_wr(8'd3, 77);
        bus_wr(CFG, 1);
        wait_done(cyc);
        bus_rd(OUTB, 1'b1, v);      check("R5 output around busy writes", v, e1);
        bus_rd(8'd3, 1'b0, v);      check("R2 busy coefficient write ignored", v, ref_coef[3]);
        bus_rd(CFG, 1'b0, v);       check("R3 busy config write ignored", v, 0);

        // R9: saturation in both directions
        for (int k = 0; k < TAPS; k++) begin
            ref_coef[k] = 8388607;
            bus_wr(8'(k), ref_coef[k]);
        end
        for (int i = 0; i < TAPS; i++) run_sample(0, SAMP, 8388607, 66);
        bus_rd(OUTB, 1'b0, v);      check("R9 positive saturation", v, 8388607);
        for (int i = 0; i < TAPS; i++) run_sample(0, SAMP, -8388608, 66);
        bus_rd(OUTB, 1'b0, v);      check("R9 negative saturation", v, -8388608);

        // R9: rounding at half an LSB
        do_reset(1'b0);
        ref_coef[0] = 1;
        bus_wr(8'd0, 1);
        run_sample(0, SAMP, 4194304, 66);
        bus_rd(OUTB, 1'b0, v);      check("R9 half rounds up", v, 1);
        run_sample(0, SAMP, 4194303, 66);
        bus_rd(OUTB, 1'b0, v);      check("R9 below half rounds down", v, 0);
        run_sample(0, SAMP, -4194305, 66);
        bus_rd(OUTB, 1'b0, v);      check("R9 negative rounding", v, -1);

        // ---------- four 16-tap channels ----------
        do_reset(1'b1);
        bus_wr(CFG, 1);
        bus_rd(CFG, 1'b0, v);       check("R3 quad mode readback", v, 1);
        check("R4 all channels request input", dma_in_req, 4'b1111);
        for (int k = 0; k < TAPS; k++) begin
            ref_coef[k] = ((k % 16) + 1) * ((k / 16) + 1) * 1000 * (((k % 3) == 0) ? -1 : 1);
            bus_wr(8'(k), ref_coef[k]);
        end
        for (int c = 0; c < NCH; c++) begin   // R7
            run_sample(c, SAMP + 8'(c), 100000 * (c + 1), 18);
            run_sample(c, SAMP + 8'(c), -70000 * (c + 2), 18);
        end

        // R11: round-robin after channel 2 is served first
        e1 = 0;
        bus_wr(SAMP + 8'd2, 222222);
        bus_wr(SAMP + 8'd0, 111111);
        bus_wr(SAMP + 8'd1, -333333);
        bus_wr(SAMP + 8'd3, 444444);
        for (int c = 0; c < NCH; c++) seen[c] = 0;
        for (int i = 0; i < 300 && order.size() < NCH; i++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++)
                if (dma_out_req[c] && !seen[c]) begin seen[c] = 1; order.push_back(c); end
        end
        check("R11 completions", order.size(), 4);
        if (order.size() == 4) begin
            check("R11 first served", order[0], 2);
            check("R11 second served", order[1], 3);
            check("R11 third served", order[2], 0);
            check("R11 fourth served", order[3], 1);
        end
        e1 = model_push(0, 111111);
        bus_rd(OUTB + 8'd0, 1'b1, v); check("R7 channel 0 result", v, e1);
        e1 = model_push(1, -333333);
        bus_rd(OUTB + 8'd1, 1'b1, v); check("R7 channel 1 result", v, e1);
        e1 = model_push(2, 222222);
        bus_rd(OUTB + 8'd2, 1'b1, v); check("R7 channel 2 result", v, e1);
        e1 = model_push(3, 444444);
        bus_rd(OUTB + 8'd3, 1'b1, v); check("R7 channel 3 result", v, e1);

        summary();
        $finish;
    end
endmodule